// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

The block is an interval timer built around an 8-bit down counter and an 8-bit reload register. Software reaches it through a narrow 4-bit register port. Software first writes the reload value one nibble at a time. It then presets the counter with a one-shot strobe and starts or stops counting with a run bit. Stopping does not disturb the count, so counting resumes from the held value. When a count arrives while the counter is at zero, the counter reloads instead of wrapping. That underflow sets a sticky interrupt flag and toggles a square-wave output.

The count source can be chosen. In the default mode the counter steps on a one-cycle enable from an internal prescaler. In event mode it steps once per falling edge of an external, asynchronous event pin, which is first synchronised inside the block. The counter is wider than the data port, so it is read as two nibbles. Reading the low nibble freezes the high nibble in a hold register, and a borrow that lands between the two reads therefore cannot tear the value.

Top module: `reload_timer`

## Requirements
- R1: After reset the counter, the reload register, the run bit, the event-mode bit, the interrupt flag and the pulse output are all 0.
- R2: A write to the control register (address 4) with bit 1 set copies the reload register into the counter at that clock edge. A preset wins over a count in the same cycle.
- R3: The counter changes only while the run bit (control bit 0) is 1. Clearing it holds the value, and setting it again resumes counting from that value.
- R4: In internal mode (control bit 2 = 0), each cycle with `tick_in` high and the run bit set decrements a nonzero counter by exactly 1.
- R5: A count that arrives while the counter holds 0x00 loads the reload value instead of 0xFF.
- R6: An underflow sets the interrupt flag, which drives `irq`. Writing 1 to status bit 0 (address 5) clears it, and an underflow in the same cycle as the clear leaves it set.
- R7: `pulse_out` toggles on every underflow.
- R8: Reading address 2 returns counter bits 3:0 and captures counter bits 7:4. Reading address 3 returns the captured bits, not the live ones.
- R9: In event mode (control bit 2 = 1), `tick_in` is ignored. Each falling edge of `evt_in` steps the counter once, three clock edges after the edge is presented. A rising edge does nothing.
- R10: Register map: 0 = reload bits 3:0, 1 = reload bits 7:4, 4 = control, read back as {0, event mode, 0, run}, 5 = status {0, 0, pulse, interrupt flag}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_in | input | 1 | One-cycle count enable from the internal prescaler |
| evt_in | input | 1 | Asynchronous external event input |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of address 2 captures the high nibble) |
| addr | input | 3 | Register address |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Read data, combinational from `addr` |
| irq | output | 1 | Sticky interrupt request |
| pulse_out | output | 1 | Output that toggles on each underflow |

## Verification
Register writes, presets, `tick_in` counts and interrupt clears all take effect at the single clock edge that samples them. The bench therefore drives every stimulus on a falling edge and checks `irq`, `pulse_out` and read data one nanosecond after the next falling edge. Read data is combinational, so the scoreboard monitor compares `rdata` during the very cycle in which `rd_en` is high. In event mode a falling edge of `evt_in` reaches the counter on the third rising edge. The bench waits four cycles after each event-pin change before it reads, so no check can land on an in-flight edge.

// File: rtl/timer_pkg.sv
// Package: shared register addresses and control bit positions for the
// reloadable down-counting timer. Assumes a 3-bit register address.
package timer_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_RLD_LO = 3'd0,
        REG_RLD_HI = 3'd1,
        REG_CNT_LO = 3'd2,
        REG_CNT_HI = 3'd3,
        REG_CTRL   = 3'd4,
        REG_STAT   = 3'd5
    } reg_sel_e;

    localparam int CTRL_RUN_BIT    = 0;
    localparam int CTRL_PRESET_BIT = 1;
    localparam int CTRL_EVENT_BIT  = 2;
    localparam int STAT_IRQ_BIT    = 0;
    localparam int STAT_PULSE_BIT  = 1;
endpackage

// File: rtl/timer_regs.sv
// Module: register file for the timer. It holds the reload value, the run and
// event-mode bits, and the high-nibble read hold register. It also produces
// one-cycle preset and interrupt-clear strobes.
// Assumes: DATA_W >= 3, and the counter is exactly two nibbles wide.
module timer_regs
    import timer_pkg::*;
#(
    parameter int DATA_W = 4,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [CNT_W-1:0]    cnt_q,
    input  logic                irq_q,
    input  logic                pulse_q,
    output logic [DATA_W-1:0]   rdata,
    output logic [CNT_W-1:0]    reload_q,
    output logic                run_q,
    output logic                event_q,
    output logic                preset,
    output logic                irq_clr
);
    logic [DATA_W-1:0] hold_hi_q;
    logic              wr_ctrl;
    logic              wr_stat;

    assign wr_ctrl = wr_en && (addr == REG_CTRL);
    assign wr_stat = wr_en && (addr == REG_STAT);
    assign preset  = wr_ctrl && wdata[CTRL_PRESET_BIT];
    assign irq_clr = wr_stat && wdata[STAT_IRQ_BIT];

    // Reload nibbles and control bits, written through the narrow port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            run_q    <= 1'b0;
            event_q  <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                REG_RLD_LO: reload_q[DATA_W-1:0]     <= wdata;
                REG_RLD_HI: reload_q[CNT_W-1:DATA_W] <= wdata;
                REG_CTRL: begin
                    run_q   <= wdata[CTRL_RUN_BIT];
                    event_q <= wdata[CTRL_EVENT_BIT];
                end
                default: ;
            endcase
        end
    end

    // Capture the high nibble when the low nibble is read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_hi_q <= '0;
        else if (rd_en && (addr == REG_CNT_LO))
            hold_hi_q <= cnt_q[CNT_W-1:DATA_W];
    end

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        rdata = '0;
        case (addr)
            REG_RLD_LO: rdata = reload_q[DATA_W-1:0];
            REG_RLD_HI: rdata = reload_q[CNT_W-1:DATA_W];
            REG_CNT_LO: rdata = cnt_q[DATA_W-1:0];
            REG_CNT_HI: rdata = hold_hi_q;
            REG_CTRL: begin
                rdata[CTRL_RUN_BIT]   = run_q;
                rdata[CTRL_EVENT_BIT] = event_q;
            end
            REG_STAT: begin
                rdata[STAT_IRQ_BIT]   = irq_q;
                rdata[STAT_PULSE_BIT] = pulse_q;
            end
            default: rdata = '0;
        endcase
    end

    // R8: a low-nibble read leaves the live high nibble in the hold register.
    p_hold_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == REG_CNT_LO) |=> hold_hi_q == $past(cnt_q[CNT_W-1:DATA_W]));
endmodule

// File: rtl/timer_clksel.sv
// Module: count-enable selection. In event mode the external pin passes
// through a synchroniser chain and a falling-edge detector. Otherwise the
// internal prescaler tick is used. The run bit gates both sources.
// Assumes: evt_in is asynchronous, and each of its levels lasts at least two
// clock cycles.
module timer_clksel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic event_mode,
    input  logic tick_in,
    input  logic evt_in,
    output logic cnt_en
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   evt_prev_q;
    logic                   evt_fall;

    // Synchroniser chain: one flop per stage.
    genvar i;
    generate
        for (i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                // First stage samples the asynchronous pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= evt_in;
                end
            end else begin : g_next
                // Later stages resolve metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    // Previous synchronised level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_prev_q <= 1'b0;
        else        evt_prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign evt_fall = evt_prev_q && !sync_q[SYNC_STAGES-1];
    assign cnt_en   = run && (event_mode ? evt_fall : tick_in);

    // R9: each detected edge is a single-cycle enable.
    p_single_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_fall |=> !evt_fall);
    // R3: no count while stopped.
    p_gate_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !cnt_en);
endmodule

// File: rtl/timer_core.sv
// Module: the down counter with reload on underflow, the sticky interrupt
// flag and the toggling pulse output. A preset takes priority over a count.
// Assumes: cnt_en, preset and irq_clr are single-cycle synchronous strobes.
module timer_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             preset,
    input  logic             irq_clr,
    input  logic [CNT_W-1:0] reload_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             irq_q,
    output logic             pulse_q
);
    logic underflow;

    assign underflow = cnt_en && !preset && (cnt_q == '0);

    // Counter: preset, then reload on underflow, then decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (preset)
            cnt_q <= reload_q;
        else if (cnt_en)
            cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
    end

    // Interrupt flag: an underflow sets it with priority over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         irq_q <= 1'b0;
        else if (underflow) irq_q <= 1'b1;
        else if (irq_clr)   irq_q <= 1'b0;
    end

    // Pulse output: toggles once per underflow.
    always_ff @(posedge clk) begin
        if (!rst_n)         pulse_q <= 1'b0;
        else if (underflow) pulse_q <= !pulse_q;
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !preset) |=> $stable(cnt_q));
    p_preset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> cnt_q == $past(reload_q));
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !preset && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !preset && cnt_q == '0) |=> cnt_q == $past(reload_q));
    p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !preset && cnt_q == '0) |=> irq_q);
    p_irq_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !(cnt_en && !preset && cnt_q == '0)) |=> !irq_q);
    p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !preset && cnt_q == '0) |=> pulse_q != $past(pulse_q));
endmodule

// File: rtl/reload_timer.sv
// Module: top of the reloadable 8-bit down-counting timer. It connects the
// register file, the count-source selector and the counter core.
// Assumes: the prescaler that produces tick_in lives outside the block.
module reload_timer
    import timer_pkg::*;
#(
    parameter int DATA_W      = 4,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              evt_in,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              pulse_out
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_q;
    logic             run_q;
    logic             event_q;
    logic             preset;
    logic             irq_clr;
    logic             cnt_en;
    logic             irq_q;
    logic             pulse_q;

    timer_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .cnt_q(cnt_q), .irq_q(irq_q),
        .pulse_q(pulse_q), .rdata(rdata), .reload_q(reload_q),
        .run_q(run_q), .event_q(event_q), .preset(preset), .irq_clr(irq_clr)
    );

    timer_clksel #(.SYNC_STAGES(SYNC_STAGES)) u_clksel (
        .clk(clk), .rst_n(rst_n), .run(run_q), .event_mode(event_q),
        .tick_in(tick_in), .evt_in(evt_in), .cnt_en(cnt_en)
    );

    timer_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .preset(preset),
        .irq_clr(irq_clr), .reload_q(reload_q), .cnt_q(cnt_q),
        .irq_q(irq_q), .pulse_q(pulse_q)
    );

    assign irq       = irq_q;
    assign pulse_out = pulse_q;
endmodule

// File: tb/reload_timer_tb.sv
module reload_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_in = 1'b0;
    logic       evt_in = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [3:0] wdata = '0;
    logic [3:0] rdata;
    logic       irq;
    logic       pulse_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct { logic [3:0] exp; string tag; } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    reload_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .evt_in(evt_in),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .pulse_out(pulse_out)
    );

    // Monitor: pops the scoreboard and compares during each read cycle.
    initial forever begin
        @(negedge clk);
        #1;
        if (rd_en) begin
            exp_t e;
            e = sb_q.pop_front();
            n_run++;
            if (rdata !== e.exp) begin
                n_fail++;
                $display("FAIL %s: rdata=%h expected=%h", e.tag, rdata, e.exp);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [3:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [3:0] e, input string tag);
        exp_t it;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick_in = 1'b1;
            @(negedge clk); tick_in = 1'b0;
        end
    endtask

    task automatic evt_set(input logic v);
        @(negedge clk); evt_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic e, input string tag);
        #1;
        n_run++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(irq, 1'b0, "R1 irq");
        chk(pulse_out, 1'b0, "R1 pulse");
        rd(3'd2, 4'h0, "R1 cnt lo");
        rd(3'd3, 4'h0, "R1 cnt hi");
        rd(3'd4, 4'h0, "R1 ctrl");
        rd(3'd0, 4'h0, "R1 reload lo");
        // R10 reload write/readback
        wr(3'd0, 4'h6); wr(3'd1, 4'hA);
        rd(3'd0, 4'h6, "R10 reload lo");
        rd(3'd1, 4'hA, "R10 reload hi");
        // R2 preset
        wr(3'd4, 4'b0010);
        rd(3'd2, 4'h6, "R2 preset lo");
        rd(3'd3, 4'hA, "R2 preset hi");
        // R4 counting
        wr(3'd4, 4'b0001);
        rd(3'd4, 4'b0001, "R10 ctrl run");
        tick(3);
        rd(3'd2, 4'h3, "R4 after 3 ticks");
        // R3 stop holds, resume continues
        wr(3'd4, 4'b0000);
        tick(5);
        rd(3'd2, 4'h3, "R3 stopped lo");
        rd(3'd3, 4'hA, "R3 stopped hi");
        wr(3'd4, 4'b0001);
        tick(1);
        rd(3'd2, 4'h2, "R3 resumed");
        // R8 torn-read protection
        wr(3'd0, 4'h0); wr(3'd1, 4'h1);
        wr(3'd4, 4'b0011);
        rd(3'd2, 4'h0, "R8 lo of 0x10");
        tick(1);
        rd(3'd3, 4'h1, "R8 held hi");
        rd(3'd2, 4'hF, "R8 lo of 0x0F");
        rd(3'd3, 4'h0, "R8 hi of 0x0F");
        // R5/R6/R7 underflow
        wr(3'd0, 4'h2); wr(3'd1, 4'h0);
        wr(3'd4, 4'b0011);
        tick(2);
        chk(irq, 1'b0, "R6 no irq at zero");
        rd(3'd2, 4'h0, "R5 at zero");
        tick(1);
        chk(irq, 1'b1, "R6 irq on underflow");
        chk(pulse_out, 1'b1, "R7 first toggle");
        rd(3'd2, 4'h2, "R5 reload lo");
        rd(3'd3, 4'h0, "R5 reload hi not F");
        rd(3'd5, 4'b0011, "R10 status");
        // R6 sticky, then clear
        tick(1);
        chk(irq, 1'b1, "R6 sticky");
        wr(3'd5, 4'b0001);
        chk(irq, 1'b0, "R6 cleared");
        // R6 same-cycle underflow beats clear
        tick(1);
        @(negedge clk); tick_in = 1'b1; wr_en = 1'b1; addr = 3'd5; wdata = 4'b0001;
        @(negedge clk); tick_in = 1'b0; wr_en = 1'b0;
        chk(irq, 1'b1, "R6 underflow wins over clear");
        chk(pulse_out, 1'b0, "R7 second toggle");
        rd(3'd2, 4'h2, "R5 second reload");
        // R9 event mode
        wr(3'd5, 4'b0001);
        chk(irq, 1'b0, "R6 clear before event");
        wr(3'd4, 4'b0101);
        rd(3'd4, 4'b0101, "R10 ctrl event");
        tick(3);
        rd(3'd2, 4'h2, "R9 tick ignored");
        evt_set(1'b1);
        rd(3'd2, 4'h2, "R9 rising edge ignored");
        evt_set(1'b0);
        rd(3'd2, 4'h1, "R9 one fall one step");
        evt_set(1'b1); evt_set(1'b0);
        rd(3'd2, 4'h0, "R9 second fall");
        evt_set(1'b1); evt_set(1'b0);
        chk(irq, 1'b1, "R9 event underflow irq");
        chk(pulse_out, 1'b1, "R9 event underflow pulse");
        rd(3'd2, 4'h2, "R9 event reload");
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    // Ends the run on completion or on watchdog expiry.
    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=done");
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule